// File: doc/BRIEF.md
# Serial ADC Frame Length Controller

This block is the host side of a serial link to a sampling analog-to-digital converter whose serial word length is not fixed. The converter expects a set number of serial clocks in every exchange. That number depends on the output word format (8, 12 or 16 bits) and on whether a sign bit is appended. The controller keeps its own copy of the format the converter is using and generates exactly that many clocks. It also shifts the instruction byte out and collects the returned word into a parallel result.

The format copy is updated only by requests that the converter itself treats as format-changing: a conversion start or a sign-bit change. Any other exchange that asks for a different format raises an error pulse, and the copy stays as it was. Two framing modes are supported. In continuous mode chip select stays low across exchanges, so every exchange must carry the full word length. In strobed mode chip select is pulsed for each exchange, and non-conversion instructions may use a short byte-length exchange.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, `cs_n` is high, `sclk` is low, `busy`, `res_valid` and `fmt_err` are low. The tracked format is 12 bits with sign, MSB first, so the first exchange carries 13 clocks.
- R2: The clock count of a full-length exchange equals the tracked word length. Format code 0 gives 8, code 1 gives 12, and codes 2 and 3 give 16. One is added when sign is on.
- R3: `req_lsb_first`=0 selects MSB first: the first bit received is the most significant bit of the right-justified `res_data`. A value of 1 selects LSB first: the first bit received is bit 0. Bits above the exchange length read zero.
- R4: `req_kind` 0 (conversion start) and 1 (sign change) copy the requested format, sign and order into the tracked state. The new state takes effect from the next exchange. Kinds 2 and 3 (other instructions) leave the tracked state unchanged.
- R5: With `req_strobed`=0, every exchange uses the full tracked length. `cs_n` goes low at the accept and stays low between consecutive continuous exchanges.
- R6: With `req_strobed`=1, a kind 2 or 3 exchange uses 8 clocks, and a kind 0 or 1 exchange uses the full tracked length.
- R7: With `req_strobed`=1, `cs_n` is high for at least 2 system clocks before each exchange. In both modes it is low at every rising `sclk` edge.
- R8: `req_instr` is shifted out on `di` MSB first over the first 8 clocks, and `di` is 0 for any later clocks. `di` changes only while `sclk` is low.
- R9: A kind 2 or 3 request whose format, sign or order differs from the tracked state makes `fmt_err` pulse high for one cycle, the cycle after the accept.
- R10: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the exchange ends. `res_valid` is a one-cycle pulse in the cycle after the last falling `sclk` edge, and `busy` is low in that same cycle.
- R11: Each `sclk` half period lasts `sclk_half`+1 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 conversion start, 1 sign change, 2/3 other instruction |
| req_instr | input | 8 | Instruction byte shifted out on `di` |
| req_fmt | input | 2 | Requested word format code |
| req_sign | input | 1 | Requested sign enable |
| req_lsb_first | input | 1 | Requested bit order |
| req_strobed | input | 1 | 1 pulses chip select per exchange, 0 holds it low |
| sclk_half | input | 8 | Serial clock half period minus one, in system clocks |
| busy | output | 1 | Exchange in progress |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock |
| di | output | 1 | Serial data to converter |
| do_in | input | 1 | Serial data from converter |
| res_data | output | 17 | Received word, right-justified |
| res_valid | output | 1 | Result strobe |
| fmt_err | output | 1 | Illegal format-change request strobe |

## Verification
`fmt_err` is due one system clock after the accepting edge. `busy` rises on that same clock. `res_valid` and the result come one clock after the final falling serial edge, which is at least 2·len·(`sclk_half`+1) clocks after the accept. The bench drives inputs and samples every output at the falling system-clock edge. It counts rising `sclk` edges, records `di` at those edges and clocks its converter model on falling edges. It therefore checks clock counts, bit order and the half-period length in system clocks without depending on the order of processes at the active edge. It waits for `res_valid` with a bounded cycle loop and then checks the pulse width in the cycle that follows.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  localparam int unsigned MAX_LEN = 17;
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

  typedef enum logic [1:0] {
    KIND_CONV  = 2'd0,
    KIND_SIGN  = 2'd1,
    KIND_OTHER = 2'd2,
    KIND_RSVD  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    FMT_8   = 2'd0,
    FMT_12  = 2'd1,
    FMT_16  = 2'd2,
    FMT_16B = 2'd3
  } word_fmt_e;

  typedef struct packed {
    word_fmt_e fmt;
    logic      sign;
    logic      lsb;
  } fmt_state_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_RUN  = 2'd2
  } eng_state_e;

  function automatic logic [LEN_W-1:0] word_len(fmt_state_t s);
    logic [LEN_W-1:0] base;
    case (s.fmt)
      FMT_8:   base = LEN_W'(8);
      FMT_12:  base = LEN_W'(12);
      default: base = LEN_W'(16);
    endcase
    return base + LEN_W'(s.sign);
  endfunction

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int unsigned DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] half_div,
  output logic            tick
);

  logic [DIVW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == half_div);
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + DIVW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // two ticks never come back to back unless the half period is one clock
  assert_tick_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && (half_div != '0) && $stable(half_div)) |=> !tick);

endmodule

// File: rtl/adc_fmt_tracker.sv
module adc_fmt_tracker
  import adc_frame_pkg::*;
#(
  parameter int unsigned SHORT_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [1:0]       kind,
  input  logic [1:0]       req_fmt,
  input  logic             req_sign,
  input  logic             req_lsb,
  input  logic             strobed,
  output logic [LEN_W-1:0] frame_len,
  output logic             frame_lsb,
  output logic             fmt_err
);

  fmt_state_t cur_q, cur_d, req_s;
  logic       applies;
  logic       err_d, err_q;

  always_comb begin
    req_s   = '{fmt: word_fmt_e'(req_fmt), sign: req_sign, lsb: req_lsb};
    applies = (req_kind_e'(kind) == KIND_CONV) || (req_kind_e'(kind) == KIND_SIGN);
    cur_d   = cur_q;
    if (accept && applies) cur_d = req_s;
    err_d     = accept && !applies && (req_s != cur_q);
    frame_len = (strobed && !applies) ? LEN_W'(SHORT_LEN) : word_len(cur_q);
    frame_lsb = cur_q.lsb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '{fmt: FMT_12, sign: 1'b1, lsb: 1'b0};
      err_q <= 1'b0;
    end else begin
      cur_q <= cur_d;
      err_q <= err_d;
    end
  end

  assign fmt_err = err_q;

  // other instructions never alter the tracked format
  assert_other_keeps_fmt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !applies) |=> $stable(cur_q));

  // an error strobe only follows an accepted non-format-changing request
  assert_err_after_other_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fmt_err) |-> ($past(accept) && $past(kind[1])));

endmodule

// File: rtl/adc_shift_engine.sv
module adc_shift_engine
  import adc_frame_pkg::*;
#(
  parameter int unsigned INSTR_W = 8,
  parameter int unsigned PRE_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               strobed,
  input  logic [INSTR_W-1:0] instr,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic               frame_lsb,
  input  logic               tick,
  input  logic               do_in,
  output logic               accept,
  output logic               busy,
  output logic               run,
  output logic               cs_n,
  output logic               sclk,
  output logic               di,
  output logic [MAX_LEN-1:0] res_data,
  output logic               res_valid
);

  localparam int unsigned PW = $clog2(PRE_CYC + 1);

  eng_state_e         st_q, st_d;
  logic               sclk_q, sclk_d;
  logic               di_q, di_d;
  logic [INSTR_W-1:0] isr_q, isr_d;
  logic [LEN_W-1:0]   bit_q, bit_d;
  logic [LEN_W-1:0]   len_q, len_d;
  logic               lsb_q, lsb_d;
  logic [MAX_LEN-1:0] rx_q, rx_d;
  logic [MAX_LEN-1:0] res_q, res_d;
  logic               vld_q, vld_d;
  logic               hold_q, hold_d;
  logic [PW-1:0]      pre_q, pre_d;

  assign accept = req_valid && (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    sclk_d = sclk_q;
    di_d   = di_q;
    isr_d  = isr_q;
    bit_d  = bit_q;
    len_d  = len_q;
    lsb_d  = lsb_q;
    rx_d   = rx_q;
    res_d  = res_q;
    vld_d  = 1'b0;
    hold_d = hold_q;
    pre_d  = pre_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          sclk_d = 1'b0;
          di_d   = instr[INSTR_W-1];
          isr_d  = {instr[INSTR_W-2:0], 1'b0};
          bit_d  = '0;
          len_d  = frame_len;
          lsb_d  = frame_lsb;
          rx_d   = '0;
          pre_d  = '0;
          if (strobed) begin
            st_d   = ST_PRE;
            hold_d = 1'b0;
          end else begin
            st_d   = ST_RUN;
            hold_d = 1'b1;
          end
        end
      end
      ST_PRE: begin
        if (pre_q == PW'(PRE_CYC - 1)) st_d = ST_RUN;
        else                           pre_d = pre_q + PW'(1);
      end
      ST_RUN: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            if (lsb_q) rx_d[bit_q] = do_in;
            else       rx_d = {rx_q[MAX_LEN-2:0], do_in};
          end else begin
            sclk_d = 1'b0;
            if (bit_q == len_q - LEN_W'(1)) begin
              st_d  = ST_IDLE;
              res_d = rx_q;
              vld_d = 1'b1;
              di_d  = 1'b0;
            end else begin
              bit_d = bit_q + LEN_W'(1);
              di_d  = isr_q[INSTR_W-1];
              isr_d = {isr_q[INSTR_W-2:0], 1'b0};
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      di_q   <= 1'b0;
      isr_q  <= '0;
      bit_q  <= '0;
      len_q  <= '0;
      lsb_q  <= 1'b0;
      rx_q   <= '0;
      res_q  <= '0;
      vld_q  <= 1'b0;
      hold_q <= 1'b0;
      pre_q  <= '0;
    end else begin
      st_q   <= st_d;
      sclk_q <= sclk_d;
      di_q   <= di_d;
      isr_q  <= isr_d;
      bit_q  <= bit_d;
      len_q  <= len_d;
      lsb_q  <= lsb_d;
      rx_q   <= rx_d;
      res_q  <= res_d;
      vld_q  <= vld_d;
      hold_q <= hold_d;
      pre_q  <= pre_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign run       = (st_q == ST_RUN);
  assign cs_n      = !((st_q == ST_RUN) || hold_q);
  assign sclk      = sclk_q;
  assign di        = di_q;
  assign res_data  = res_q;
  assign res_valid = vld_q;

  // serial clock rests low outside an exchange
  assert_sclk_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_RUN) |-> !sclk_q);

  // the bit counter stays inside the latched frame length
  assert_bit_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> (bit_q < len_q));

  // continuous mode keeps chip select low unless a strobed request arrives
  assert_cont_cs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !(accept && strobed)) |=> !cs_n);

  // strobed frames begin after two high chip-select cycles
  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RUN) && ($past(st_q) == ST_PRE)) |-> ($past(cs_n) && $past(cs_n, 2)));

  // data to the converter holds while the serial clock is high
  assert_di_steady_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(di_q));

  // result strobe lasts a single cycle
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int unsigned INSTR_W = 8,
  parameter int unsigned DIVW    = 8,
  parameter int unsigned PRE_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic [INSTR_W-1:0] req_instr,
  input  logic [1:0]         req_fmt,
  input  logic               req_sign,
  input  logic               req_lsb_first,
  input  logic               req_strobed,
  input  logic [DIVW-1:0]    sclk_half,
  output logic               busy,
  output logic               cs_n,
  output logic               sclk,
  output logic               di,
  input  logic               do_in,
  output logic [MAX_LEN-1:0] res_data,
  output logic               res_valid,
  output logic               fmt_err
);

  logic             accept;
  logic             run;
  logic             tick;
  logic [LEN_W-1:0] frame_len;
  logic             frame_lsb;

  adc_fmt_tracker #(.SHORT_LEN(INSTR_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .kind      (req_kind),
    .req_fmt   (req_fmt),
    .req_sign  (req_sign),
    .req_lsb   (req_lsb_first),
    .strobed   (req_strobed),
    .frame_len (frame_len),
    .frame_lsb (frame_lsb),
    .fmt_err   (fmt_err)
  );

  adc_sclk_div #(.DIVW(DIVW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .half_div (sclk_half),
    .tick     (tick)
  );

  adc_shift_engine #(.INSTR_W(INSTR_W), .PRE_CYC(PRE_CYC)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .strobed   (req_strobed),
    .instr     (req_instr),
    .frame_len (frame_len),
    .frame_lsb (frame_lsb),
    .tick      (tick),
    .do_in     (do_in),
    .accept    (accept),
    .busy      (busy),
    .run       (run),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .di        (di),
    .res_data  (res_data),
    .res_valid (res_valid)
  );

endmodule

// File: tb/sim_adc_frame_ctrl.sv
module sim_adc_frame_ctrl;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [7:0]  req_instr;
  logic [1:0]  req_fmt;
  logic        req_sign;
  logic        req_lsb_first;
  logic        req_strobed;
  logic [7:0]  sclk_half;
  logic        busy, cs_n, sclk, di, do_in;
  logic [16:0] res_data;
  logic        res_valid, fmt_err;

  adc_frame_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_instr(req_instr), .req_fmt(req_fmt), .req_sign(req_sign),
    .req_lsb_first(req_lsb_first), .req_strobed(req_strobed), .sclk_half(sclk_half),
    .busy(busy), .cs_n(cs_n), .sclk(sclk), .di(di), .do_in(do_in),
    .res_data(res_data), .res_valid(res_valid), .fmt_err(fmt_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int nchk = 0;
  int nerr = 0;

  // bench model of the tracked format (R1 reset value)
  logic [1:0] m_fmt;
  logic       m_sign, m_lsb;

  // converter model and edge monitor
  logic [16:0] dev_word;
  int          dev_len;
  logic        dev_lsb;
  int          idx, pulse_cnt, cs_hi, cs_bad, ncyc, rise_last, rise_prev;
  logic [31:0] di_cap;
  logic        sclk_prev;

  always_comb begin
    if (idx < dev_len) do_in = dev_lsb ? dev_word[idx] : dev_word[dev_len-1-idx];
    else               do_in = 1'b0;
  end

  always @(negedge clk) begin
    if (sclk && !sclk_prev) begin
      pulse_cnt = pulse_cnt + 1;
      di_cap    = {di_cap[30:0], di};
      if (cs_n) cs_bad = cs_bad + 1;
      rise_prev = rise_last;
      rise_last = ncyc;
    end
    if (!sclk && sclk_prev) idx = idx + 1;
    if (cs_n) cs_hi = cs_hi + 1;
    sclk_prev = sclk;
    ncyc = ncyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int full_len(input logic [1:0] f, input logic s);
    int b;
    b = (f == 2'd0) ? 8 : (f == 2'd1) ? 12 : 16;
    return b + int'(s);
  endfunction

  bit prev_cont;

  task automatic xfer(input logic [1:0] kind, input logic [1:0] fmt, input logic sgn,
                      input logic lsb, input logic strb, input logic [7:0] dv,
                      input logic [7:0] ins, input logic [16:0] word);
    bit   applies, exp_err;
    int   exp_len, wait_n;
    logic [31:0] mask, exp_di;
    applies = (kind < 2);
    exp_len = (strb && !applies) ? 8 : full_len(m_fmt, m_sign);
    exp_err = !applies && ({fmt, sgn, lsb} != {m_fmt, m_sign, m_lsb});
    @(posedge clk);
    dev_word = word; dev_len = exp_len; dev_lsb = m_lsb; idx = 0;
    pulse_cnt = 0; cs_hi = 0; cs_bad = 0; di_cap = '0; rise_last = 0; rise_prev = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_fmt = fmt; req_sign = sgn;
    req_lsb_first = lsb; req_strobed = strb; sclk_half = dv; req_instr = ins;
    @(negedge clk);
    req_valid = 1'b0;
    chk(fmt_err == exp_err, "R9 fmt_err after accept", int'(fmt_err), int'(exp_err));
    chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
    wait_n = 0;
    while (!res_valid && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(res_valid == 1'b1, "R10 result strobe", int'(res_valid), 1);
    chk(busy == 1'b0, "R10 busy low with result", int'(busy), 0);
    chk(pulse_cnt == exp_len, "R2 R5 R6 clock count", pulse_cnt, exp_len);
    mask = (32'd1 << exp_len) - 32'd1;
    chk(({15'd0, res_data} & ~mask) == 0 && ({15'd0, res_data} == ({15'd0, word} & mask)),
        "R3 received word", int'(res_data), int'({15'd0, word} & mask));
    exp_di = {24'd0, ins} << (exp_len - 8);
    chk((di_cap & mask) == exp_di, "R8 instruction on di", int'(di_cap & mask), int'(exp_di));
    chk(cs_bad == 0, "R7 cs low at rising sclk", cs_bad, 0);
    if (strb)      chk(cs_hi >= 2, "R7 strobed cs gap", cs_hi, 2);
    else if (prev_cont) chk(cs_hi == 0, "R5 cs held low", cs_hi, 0);
    chk(rise_last - rise_prev == 2 * (int'(dv) + 1), "R11 sclk period",
        rise_last - rise_prev, 2 * (int'(dv) + 1));
    @(negedge clk);
    chk(res_valid == 1'b0, "R10 single-cycle strobe", int'(res_valid), 0);
    if (applies) begin m_fmt = fmt; m_sign = sgn; m_lsb = lsb; end  // R4
    prev_cont = !strb;
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  fmt;
    logic        sgn;
    logic        lsb;
    logic        strb;
    logic [7:0]  dv;
    logic [7:0]  ins;
    logic [16:0] word;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 8'd0, 8'hA5, 17'h1B2C3},  // R1 first exchange 13
    '{2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 8'd1, 8'h3C, 17'h00F0F},  // R9 mismatch on other
    '{2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 8'd0, 8'h81, 17'h15555},  // R4 conv, old length
    '{2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 8'd2, 8'h7E, 17'h000B4},  // R3 lsb first, 8
    '{2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 8'd0, 8'hC3, 17'h001A6},  // R4 sign change
    '{2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 8'd1, 8'h12, 17'h0017F},  // 9 clocks, lsb
    '{2'd0, 2'd2, 1'b1, 1'b0, 1'b1, 8'd0, 8'hF0, 17'h1E3A7},  // R6 conv strobed 17
    '{2'd2, 2'd2, 1'b1, 1'b0, 1'b1, 8'd3, 8'h5A, 17'h000C9},  // R6 short 8
    '{2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 8'd0, 8'h99, 17'h00077},  // R9 kind 3 mismatch
    '{2'd0, 2'd3, 1'b0, 1'b0, 1'b1, 8'd1, 8'h0F, 17'h1ABCD},  // R2 code 3
    '{2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 8'd0, 8'hE7, 17'h0BEEF},  // 16 clocks
    '{2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 8'd0, 8'h24, 17'h00A5C}   // 12 clocks lsb
  };

  task automatic do_reset();
    rst_n = 1'b0;
    m_fmt = 2'd1; m_sign = 1'b1; m_lsb = 1'b0;
    prev_cont = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    req_valid = 1'b0; req_kind = 2'd2; req_instr = '0; req_fmt = 2'd1;
    req_sign = 1'b1; req_lsb_first = 1'b0; req_strobed = 1'b0; sclk_half = '0;
    dev_word = '0; dev_len = 0; dev_lsb = 1'b0; idx = 0; pulse_cnt = 0;
    cs_hi = 0; cs_bad = 0; ncyc = 0; rise_last = 0; rise_prev = 0;
    di_cap = '0; sclk_prev = 1'b0;
    do_reset();
    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_n after reset", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1 sclk after reset", int'(sclk), 0);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(res_valid == 1'b0 && fmt_err == 1'b0, "R1 strobes after reset",
        int'({res_valid, fmt_err}), 0);

    for (int i = 0; i < NV; i++)
      xfer(VECS[i].kind, VECS[i].fmt, VECS[i].sgn, VECS[i].lsb, VECS[i].strb,
           VECS[i].dv, VECS[i].ins, VECS[i].word);

    // R1: reset brings the length back to 13 after a format change
    xfer(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'd0, 8'h11, 17'h000AA);
    do_reset();
    xfer(2'd2, 2'd1, 1'b1, 1'b0, 1'b1, 8'd0, 8'h22, 17'h1F00F);
    xfer(2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 8'd0, 8'h33, 17'h10001);
    // R4: a repeated non-conversion request with a different format changes nothing
    xfer(2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 8'd0, 8'h44, 17'h0F0F0);
    xfer(2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 8'd0, 8'h55, 17'h01111);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL R10 watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule